// File: doc/BRIEF.md
# Byte SPI Master on a Reused Serial Shifter

This block is the synchronous shift engine of a serial port, used as a byte-wide SPI master. Software writes a byte into the data register, and that write starts a transfer. The byte goes out bit by bit on the data pin, which acts as MOSI. The shift clock is produced on a second pin, and the bits coming back on a separate MISO input are shifted into the same register. When the transfer ends, software reads the data register to get the received byte.

No mode field selects the clock polarity. The idle level of the clock pin is whatever software last wrote into a one-bit clock latch, and every transfer starts and ends at that level. A phase bit chooses whether data is launched before or on the leading edge. An order bit chooses whether the least or the most significant bit goes first. The end of a transfer is reported only through a sticky transmit-done flag. The receive flag exists but stays low in this mode.

The control sits in a small state machine:
- **IDLE** waits for a data write. The transition IDLE→LEAD is taken on that write.
- **LEAD** holds the clock at its idle level for half a period. The transition LEAD→TRAIL fires on the half-period tick, which also produces the leading edge.
- **TRAIL** holds the clock at its active level. On the next tick it produces the trailing edge, then returns TRAIL→LEAD while bits remain, or goes TRAIL→FINISH after the eighth pulse.
- **FINISH** raises the done flag. The transition FINISH→IDLE follows unconditionally one cycle later.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, the CTRL register (address 1) reads 0x04. Its fields are bit0 = clock latch (0), bit1 = phase (0) and bit2 = order (1 = LSB first). STATUS (address 2) reads 0, DATA (address 0) reads 0, `sclk_o` is 0 and `rx_done_o` is 0.
- R2: A write to DATA while idle starts a transfer with no other enable. `busy_o` (also STATUS bit2) is 1 from the cycle after the write until the transfer ends.
- R3: Each transfer makes exactly eight clock pulses with eight rising edges on `sclk_o`. Each half period lasts HALF_DIV system cycles. Busy lasts 16·HALF_DIV+1 cycles. Whenever the block is not busy, `sclk_o` equals the clock latch, CTRL bit0.
- R4: With CTRL bit2 = 1 the byte leaves bit 0 first; with bit2 = 0 it leaves bit 7 first.
- R5: With CTRL bit1 = 0, the first bit is on `mosi_o` before the first leading edge, MISO is sampled on leading edges, and MOSI changes on trailing edges. With bit1 = 1, MOSI changes on leading edges and MISO is sampled on trailing edges. A leading edge is one that leaves the idle level.
- R6: After a transfer, a read of DATA returns the eight sampled MISO bits, placed in the same order as transmission. The first bit received lands in bit 0 when LSB first, or in bit 7 when MSB first.
- R7: `tx_done_o` (STATUS bit0) becomes 1 in the cycle after the last trailing edge. It stays 1 until a write to STATUS with bit0 = 1 clears it. A write with bit0 = 0 leaves it set.
- R8: `rx_done_o` (STATUS bit1) is never 1.
- R9: While busy, writes to DATA and to CTRL are ignored. The byte in flight, the received byte and the CTRL contents are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 DATA, 1 CTRL, 2 STATUS |
| reg_wdata | input | NBITS (8) | Write data |
| reg_rdata | output | NBITS (8) | Read data for `reg_addr`, combinational |
| sclk_o | output | 1 | Shift clock pin |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| tx_done_o | output | 1 | Sticky transfer-complete flag |
| rx_done_o | output | 1 | Receive flag, held low |

## Verification
Suppose the bit counter or the state goes wrong. The pulse count then shows at the clock pin in the same transfer, as seven or nine rising edges, and the busy window changes length by a multiple of 2·HALF_DIV cycles. A wrong shift direction or a wrong sample edge corrupts the byte that the bench slave captures, or the byte read back from DATA, as soon as the transfer ends. A done flag or a control register that misbehaves is visible at the next status or control read. The bench sweeps every combination of polarity, phase and order against eight data patterns, so each such fault shows within a few hundred cycles.

// File: rtl/sms_pkg.sv
package sms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_FINISH
    } sms_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // bit2 order, bit1 phase, bit0 clock latch
    typedef struct packed {
        logic lsb_first;
        logic cpha;
        logic clk_latch;
    } sms_ctrl_t;

    localparam sms_ctrl_t CTRL_RST = '{lsb_first: 1'b1, cpha: 1'b0, clk_latch: 1'b0};

endpackage

// File: rtl/sms_half_timer.sv
module sms_half_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/sms_sequencer.sv
module sms_sequencer
    import sms_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tick,
    output sms_state_e state,
    output logic       run,
    output logic       load,
    output logic       lead_tick,
    output logic       trail_tick,
    output logic       last_tick,
    output logic       tx_set
);
    localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

    sms_state_e    state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;

    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                bit_d = '0;
                if (start) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (bit_q == LAST_BIT) begin
                        state_d = ST_FINISH;
                        bit_d   = '0;
                    end else begin
                        state_d = ST_LEAD;
                        bit_d   = bit_q + 1'b1;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        load       = 1'b0;
        lead_tick  = 1'b0;
        trail_tick = 1'b0;
        last_tick  = 1'b0;
        tx_set     = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_LEAD: begin
                run       = 1'b1;
                lead_tick = tick;
            end
            ST_TRAIL: begin
                run        = 1'b1;
                trail_tick = tick;
                last_tick  = tick && (bit_q == LAST_BIT);
            end
            ST_FINISH: tx_set = 1'b1;
            default: ;
        endcase
    end

    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (bit_q == '0)); // R3
    AST_FINISH_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> $past(last_tick)); // R3
    AST_LEAD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_LEAD)); // R2
endmodule

// File: rtl/sms_datapath.sv
module sms_datapath #(
    parameter int NBITS       = 8,
    parameter int SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] load_data,
    input  logic             lsb_first,
    input  logic             cpha,
    input  logic             clk_latch,
    input  logic             lead_tick,
    input  logic             trail_tick,
    input  logic             last_tick,
    input  logic             miso_i,
    output logic             sclk_q,
    output logic             mosi_q,
    output logic [NBITS-1:0] shreg
);
    logic miso_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign miso_s = miso_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], miso_i};
            end
            assign miso_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    logic [NBITS-1:0] sr_q;
    logic             out_bit, first_bit, sample, launch;

    assign shreg     = sr_q;
    assign out_bit   = lsb_first ? sr_q[0] : sr_q[NBITS-1];
    assign first_bit = lsb_first ? load_data[0] : load_data[NBITS-1];
    assign sample    = cpha ? trail_tick : lead_tick;
    assign launch    = cpha ? lead_tick : (trail_tick && !last_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
        end else if (load) begin
            sr_q   <= load_data;
            sclk_q <= clk_latch;
            if (!cpha) mosi_q <= first_bit;
        end else begin
            if (lead_tick || trail_tick) sclk_q <= ~sclk_q;
            if (launch) mosi_q <= out_bit;
            if (sample) begin
                if (lsb_first) sr_q <= {miso_s, sr_q[NBITS-1:1]};
                else           sr_q <= {sr_q[NBITS-2:0], miso_s};
            end
        end
    end

    AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_tick || trail_tick) |=> (sclk_q != $past(sclk_q))); // R3
    AST_MOSI_STILL_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !load) |=> $stable(mosi_q)); // R5
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import sms_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int NBITS       = 8,
    parameter int SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NBITS-1:0] reg_wdata,
    output logic [NBITS-1:0] reg_rdata,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             busy_o,
    output logic             tx_done_o,
    output logic             rx_done_o
);
    sms_ctrl_t        ctrl_q;
    logic             tx_done_q;
    sms_state_e       state;
    logic             run, load, lead_tick, trail_tick, last_tick, tx_set, tick;
    logic             sclk_q, mosi_q;
    logic [NBITS-1:0] shreg;
    logic             wr_data, wr_ctrl, wr_clr, busy;

    assign busy    = (state != ST_IDLE);
    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL) && !busy;
    assign wr_clr  = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_ctrl) begin
            ctrl_q <= sms_ctrl_t'(reg_wdata[2:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tx_done_q <= 1'b0;
        else if (tx_set) tx_done_q <= 1'b1;
        else if (wr_clr) tx_done_q <= 1'b0;
    end

    sms_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    sms_sequencer #(.NBITS(NBITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_data),
        .tick      (tick),
        .state     (state),
        .run       (run),
        .load      (load),
        .lead_tick (lead_tick),
        .trail_tick(trail_tick),
        .last_tick (last_tick),
        .tx_set    (tx_set)
    );

    sms_datapath #(.NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (reg_wdata),
        .lsb_first (ctrl_q.lsb_first),
        .cpha      (ctrl_q.cpha),
        .clk_latch (ctrl_q.clk_latch),
        .lead_tick (lead_tick),
        .trail_tick(trail_tick),
        .last_tick (last_tick),
        .miso_i    (miso_i),
        .sclk_q    (sclk_q),
        .mosi_q    (mosi_q),
        .shreg     (shreg)
    );

    assign sclk_o    = busy ? sclk_q : ctrl_q.clk_latch;
    assign mosi_o    = mosi_q;
    assign busy_o    = busy;
    assign tx_done_o = tx_done_q;
    assign rx_done_o = 1'b0;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = shreg;
            ADDR_CTRL: reg_rdata[2:0] = ctrl_q;
            ADDR_STAT: reg_rdata[2:0] = {busy, 1'b0, tx_done_q};
            default:   reg_rdata = '0;
        endcase
    end

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q)); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !busy) |=> busy); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_q && !wr_clr) |=> tx_done_q); // R7
    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_q) |-> $past(state == ST_FINISH)); // R7
    AST_IDLE_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> (sclk_q == ctrl_q.clk_latch)); // R3
endmodule

// File: tb/spi_shift_master_test.sv
module spi_shift_master_test;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sclk_o, mosi_o, busy_o, tx_done_o, rx_done_o;
    logic       miso_i = 1'b0;

    always #2.5 clk = ~clk;

    spi_shift_master #(.HALF_DIV(H), .NBITS(8), .SYNC_STAGES(0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .busy_o(busy_o),
        .tx_done_o(tx_done_o), .rx_done_o(rx_done_o)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // slave model
    logic       act = 1'b0;
    logic       s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b1;
    logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
    int         oidx = 0, iidx = 0, rises = 0, bcnt = 0;

    function automatic int bpos(input int i);
        return s_lsb ? i : 7 - i;
    endfunction

    always @(sclk_o) begin
        if (act) begin
            logic lead;
            lead = (sclk_o != s_cpol);
            if (sclk_o) rises++;
            if (s_cpha ? !lead : lead) begin
                if (iidx < 8) s_rx[bpos(iidx)] = mosi_o;
                iidx++;
            end else begin
                if (oidx < 8) miso_i = s_tx[bpos(oidx)];
                oidx++;
            end
        end
    end

    always @(negedge clk) if (act && busy_o) bcnt++;

    task automatic begin_xfer(input logic [2:0] cfg, input logic [7:0] m,
                              input logic [7:0] s);
        wr(2'd1, {5'd0, cfg});
        wr(2'd2, 8'h01);
        s_lsb = cfg[2]; s_cpha = cfg[1]; s_cpol = cfg[0];
        s_tx = s; s_rx = 8'h00; iidx = 0; rises = 0; bcnt = 0;
        if (!cfg[1]) begin
            miso_i = s[bpos(0)];
            oidx = 1;
        end else begin
            miso_i = 1'b0;
            oidx = 0;
        end
        act = 1'b1;
        wr(2'd0, m);
        chk(busy_o == 1'b1, "R2", "busy after write", busy_o, 1);
    endtask

    task automatic end_xfer(input logic [2:0] cfg, input logic [7:0] m,
                            input logic [7:0] s);
        logic [7:0] d;
        while (busy_o) @(negedge clk);
        act = 1'b0;
        chk(rises == 8, "R3", "rising edges", rises, 8);
        chk(bcnt == 16 * H + 1, "R3", "busy cycles", bcnt, 16 * H + 1);
        chk(sclk_o == cfg[0], "R3", "idle clock level", sclk_o, cfg[0]);
        chk(s_rx == m, "R4 R5", "byte seen by slave", s_rx, m);
        rd(2'd0, d);
        chk(d == s, "R6", "received byte", d, s);
        chk(tx_done_o == 1'b1, "R7", "done flag", tx_done_o, 1);
        chk(rx_done_o == 1'b0, "R8", "receive flag", rx_done_o, 0);
    endtask

    logic finished = 1'b0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pats [8];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hC3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, d); chk(d == 8'h04, "R1", "ctrl reset", d, 8'h04);
        rd(2'd2, d); chk(d == 8'h00, "R1", "status reset", d, 8'h00);
        rd(2'd0, d); chk(d == 8'h00, "R1", "data reset", d, 8'h00);
        chk(sclk_o == 1'b0, "R1", "sclk reset", sclk_o, 0);
        chk(rx_done_o == 1'b0, "R1", "rx flag reset", rx_done_o, 0);

        // sweep: order x phase x polarity x patterns
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] m, s;
                m = pats[p];
                s = {pats[p][3:0], pats[p][7:4]} ^ 8'h96 ^ 8'(c);
                begin_xfer(3'(c), m, s);
                end_xfer(3'(c), m, s);
            end
        end

        // R9 writes while busy are ignored
        begin_xfer(3'b110, 8'h4D, 8'hB2);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'hE7);
        wr(2'd1, 8'h01);
        end_xfer(3'b110, 8'h4D, 8'hB2);
        rd(2'd1, d); chk(d == 8'h06, "R9", "ctrl after busy write", d, 8'h06);
        chk(busy_o == 1'b0, "R9", "no restart", busy_o, 0);

        // R7 sticky flag and clear
        repeat (5) @(negedge clk);
        rd(2'd2, d); chk(d[0] == 1'b1, "R7", "flag still set", d[0], 1);
        wr(2'd2, 8'h00);
        rd(2'd2, d); chk(d[0] == 1'b1, "R7", "flag after zero write", d[0], 1);
        chk(d[1] == 1'b0, "R8", "status rx bit", d[1], 0);
        wr(2'd2, 8'h01);
        rd(2'd2, d); chk(d[0] == 1'b0, "R7", "flag cleared", d[0], 0);

        // R3 idle level follows latch without a transfer
        wr(2'd1, 8'h05);
        #1 chk(sclk_o == 1'b1, "R3", "latch high idle", sclk_o, 1);
        wr(2'd1, 8'h04);
        #1 chk(sclk_o == 1'b0, "R3", "latch low idle", sclk_o, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule